// File: doc/BRIEF.md
# Serial Interface Request Pin Controller

This block owns the single request pin of a serial host port that can operate as SPI or I2C, in either the master or the slave role. A two-bit enable field decides what the pin does. When the field is zero the pin is never driven. When the field is non-zero in the master role, the pin is an active-low input. Its level is synchronised and then used to pause the serial clock whenever the far side deasserts it. When the field is non-zero in the slave role, the pin is an active-low output that tells the remote master whether the local shift register can take or give a word.

The enable field lives in a small register inside the block. That register is cleared by the asynchronous hardware reset and by a synchronous software reset. A write to the field only takes effect while the port is idle. A write made while the port is busy is dropped, and the old setting stays in force.

Top module: `srq_pin_ctrl`

## Requirements
- R1: After hardware reset (rst_n low) the enable field is 00, req_pin_oe is 0, req_pin_out is 1 and clk_suspend is 0.
- R2: With enable field 00, req_pin_oe and clk_suspend stay 0 in both roles and for any flag or pin levels.
- R3: In the master role (is_master=1) with a non-zero enable field, req_pin_oe is 0. clk_suspend equals the level req_pin_in had two rising edges earlier, so a high (deasserted) pin pauses the clock.
- R4: In the slave role with enable field 01, req_pin_oe is 1 and req_pin_out is 0 exactly when rx_ready is 1.
- R5: In the slave role with enable field 10, req_pin_oe is 1 and req_pin_out is 0 exactly when tx_ready is 1.
- R6: In the slave role with enable field 11 and is_i2c=1, req_pin_out is 0 when tx_ready or rx_ready is 1.
- R7: In the slave role with enable field 11 and is_i2c=0 (SPI), req_pin_out is 0 only when tx_ready and rx_ready are both 1.
- R8: A write (en_wr=1) while busy=1 is ignored, and the previous enable field keeps controlling the pin.
- R9: soft_rst=1 clears the enable field at the next rising edge and takes priority over a write in the same cycle.
- R10: A write with busy=0 loads en_wdata at the rising edge, and the new behaviour is visible from that edge on.
- R11: Whenever req_pin_oe is 0, req_pin_out is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset of the enable field |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| is_i2c | input | 1 | 1 = I2C protocol, 0 = SPI protocol |
| busy | input | 1 | Port is in the middle of a transfer |
| en_wr | input | 1 | Write strobe for the enable field |
| en_wdata | input | 2 | New enable field value |
| tx_ready | input | 1 | Shift register can accept a word to transmit |
| rx_ready | input | 1 | Shift register can take a new received word |
| req_pin_in | input | 1 | Pad input level of the request pin |
| req_pin_out | output | 1 | Pad output level, active low |
| req_pin_oe | output | 1 | Pad output enable |
| clk_suspend | output | 1 | Request to pause the serial clock |

## Verification
The slave readiness output is driven through every pairing of tx_ready and rx_ready under each enable code. For code 11 it is tried under both protocols, and the pairings with exactly one flag set are the ones that separate OR from AND. A directed step on req_pin_in in the master role confirms that clk_suspend follows after the second edge and not after the first. Writes arriving while busy, and writes colliding with a software reset, are checked through the pin behaviour that follows them. A long seeded random run then mixes roles, protocols, writes and pin levels against a cycle model kept in the bench.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int EN_W = 2;

    typedef enum logic [EN_W-1:0] {
        EN_OFF  = 2'b00,
        EN_RX   = 2'b01,
        EN_TX   = 2'b10,
        EN_BOTH = 2'b11
    } en_code_e;

    typedef struct packed {
        en_code_e code;
    } en_state_t;
endpackage

// File: rtl/srq_en_reg.sv
module srq_en_reg
    import srq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            busy,
    input  logic            wr,
    input  logic [EN_W-1:0] wdata,
    output en_code_e        code
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.code = EN_OFF;
        end else if (wr && !busy) begin
            st_d.code = en_code_e'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: EN_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
endmodule

// File: rtl/srq_sync.sv
module srq_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                sy_d       = sy_q;
                sy_d.chain = din;
            end
        end else begin : g_multi
            always_comb begin
                sy_d       = sy_q;
                sy_d.chain = {sy_q.chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign dout = sy_q.chain[STAGES-1];
endmodule

// File: rtl/srq_ready_sel.sv
module srq_ready_sel
    import srq_pkg::*;
(
    input  en_code_e code,
    input  logic     is_i2c,
    input  logic     tx_ready,
    input  logic     rx_ready,
    output logic     ready
);
    always_comb begin
        unique case (code)
            EN_RX:   ready = rx_ready;
            EN_TX:   ready = tx_ready;
            EN_BOTH: ready = is_i2c ? (tx_ready | rx_ready) : (tx_ready & rx_ready);
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/srq_pin_ctrl.sv
module srq_pin_ctrl
    import srq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            is_master,
    input  logic            is_i2c,
    input  logic            busy,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            tx_ready,
    input  logic            rx_ready,
    input  logic            req_pin_in,
    output logic            req_pin_out,
    output logic            req_pin_oe,
    output logic            clk_suspend
);
    en_code_e en_q;
    logic     pin_synced;
    logic     slave_ready;
    logic     en_any;

    srq_en_reg u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .busy     (busy),
        .wr       (en_wr),
        .wdata    (en_wdata),
        .code     (en_q)
    );

    // Pin idles high (deasserted) so a freshly reset chain asks for a pause.
    srq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_pin_in),
        .dout  (pin_synced)
    );

    srq_ready_sel u_sel (
        .code     (en_q),
        .is_i2c   (is_i2c),
        .tx_ready (tx_ready),
        .rx_ready (rx_ready),
        .ready    (slave_ready)
    );

    always_comb begin
        en_any      = (en_q != EN_OFF);
        req_pin_oe  = en_any && !is_master;
        req_pin_out = req_pin_oe ? !slave_ready : 1'b1;
        clk_suspend = en_any && is_master && pin_synced;
    end
endmodule

// File: rtl/srq_pin_ctrl_chk.sv
module srq_pin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       busy,
    input logic       is_master,
    input logic       is_i2c,
    input logic       tx_ready,
    input logic       rx_ready,
    input logic       req_pin_out,
    input logic       req_pin_oe,
    input logic       clk_suspend,
    input logic [1:0] en_q
);
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 2'b00) |-> (!req_pin_oe && !clk_suspend));

    p_master_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> !req_pin_oe);

    p_spi_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pin_oe && en_q == 2'b11 && !is_i2c && !req_pin_out) |-> (tx_ready && rx_ready));

    p_i2c_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pin_oe && en_q == 2'b11 && is_i2c && (tx_ready || rx_ready)) |-> !req_pin_out);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !soft_rst) |=> $stable(en_q));

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (en_q == 2'b00));

    p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_pin_oe |-> req_pin_out);
endmodule

bind srq_pin_ctrl srq_pin_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .busy        (busy),
    .is_master   (is_master),
    .is_i2c      (is_i2c),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready),
    .req_pin_out (req_pin_out),
    .req_pin_oe  (req_pin_oe),
    .clk_suspend (clk_suspend),
    .en_q        (en_q)
);

// File: tb/srq_pin_ctrl_test.sv
module srq_pin_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       is_master = 1'b0;
    logic       is_i2c = 1'b0;
    logic       busy = 1'b0;
    logic       en_wr = 1'b0;
    logic [1:0] en_wdata = 2'b00;
    logic       tx_ready = 1'b0;
    logic       rx_ready = 1'b0;
    logic       req_pin_in = 1'b0;
    logic       req_pin_out;
    logic       req_pin_oe;
    logic       clk_suspend;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Bench-side model state
    logic [1:0] m_en = 2'b00;
    logic       m_s1 = 1'b1;
    logic       m_s2 = 1'b1;

    always #10 clk = ~clk;

    srq_pin_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .is_master   (is_master),
        .is_i2c      (is_i2c),
        .busy        (busy),
        .en_wr       (en_wr),
        .en_wdata    (en_wdata),
        .tx_ready    (tx_ready),
        .rx_ready    (rx_ready),
        .req_pin_in  (req_pin_in),
        .req_pin_out (req_pin_out),
        .req_pin_oe  (req_pin_oe),
        .clk_suspend (clk_suspend)
    );

    function automatic logic exp_oe(logic [1:0] en, logic master);
        return (en != 2'b00) && !master;
    endfunction

    function automatic logic exp_out(logic [1:0] en, logic master, logic i2c, logic tx, logic rx);
        logic rdy;
        if (!exp_oe(en, master)) return 1'b1;
        case (en)
            2'b01:   rdy = rx;
            2'b10:   rdy = tx;
            default: rdy = i2c ? (tx | rx) : (tx & rx);
        endcase
        return !rdy;
    endfunction

    function automatic logic exp_susp(logic [1:0] en, logic master, logic synced);
        return (en != 2'b00) && master && synced;
    endfunction

    function automatic string tag_of(logic [1:0] en, logic master, logic i2c);
        if (en == 2'b00) return "R2";
        if (master)      return "R3";
        if (en == 2'b01) return "R4";
        if (en == 2'b10) return "R5";
        return i2c ? "R6" : "R7";
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "req_pin_oe", req_pin_oe, exp_oe(m_en, is_master));
        chk(req, "req_pin_out", req_pin_out, exp_out(m_en, is_master, is_i2c, tx_ready, rx_ready));
        chk(req, "clk_suspend", clk_suspend, exp_susp(m_en, is_master, m_s2));
    endtask

    // Advance one edge and keep the model in step with the inputs held over it.
    task automatic tick();
        @(posedge clk);
        if (soft_rst)           m_en = 2'b00;
        else if (en_wr && !busy) m_en = en_wdata;
        m_s2 = m_s1;
        m_s1 = req_pin_in;
        @(negedge clk);
    endtask

    task automatic write_en(input logic [1:0] v);
        en_wr = 1'b1; en_wdata = v;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic sweep_flags(input string req);
        for (int k = 0; k < 4; k++) begin
            tx_ready = k[1]; rx_ready = k[0];
            #1 check_all(req);
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state, pin input held low during reset
        #1;
        chk("R1", "req_pin_oe", req_pin_oe, 1'b0);
        chk("R1", "req_pin_out", req_pin_out, 1'b1);
        chk("R1", "clk_suspend", clk_suspend, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: enable off, both roles, all flags
        is_master = 1'b0; sweep_flags("R2");
        is_master = 1'b1; req_pin_in = 1'b1; tick(); tick(); sweep_flags("R2");
        req_pin_in = 1'b0; tick(); tick();

        // R10 / R4: write 01 in slave role
        is_master = 1'b0;
        write_en(2'b01);
        sweep_flags("R4");
        chk("R10", "req_pin_oe after write", req_pin_oe, 1'b1);

        // R5
        write_en(2'b10); sweep_flags("R5");
        // R6 and R7
        write_en(2'b11);
        is_i2c = 1'b1; sweep_flags("R6");
        is_i2c = 1'b0; sweep_flags("R7");

        // R8: write while busy ignored
        write_en(2'b01);
        busy = 1'b1; write_en(2'b10); busy = 1'b0;
        tx_ready = 1'b0; rx_ready = 1'b1;
        #1 chk("R8", "req_pin_out keeps code 01", req_pin_out, 1'b0);
        tx_ready = 1'b1; rx_ready = 1'b0;
        #1 chk("R8", "req_pin_out keeps code 01", req_pin_out, 1'b1);

        // R9: soft reset beats a simultaneous write
        soft_rst = 1'b1; write_en(2'b11); soft_rst = 1'b0;
        #1 chk("R9", "req_pin_oe", req_pin_oe, 1'b0);
        chk("R11", "req_pin_out idle", req_pin_out, 1'b1);

        // R3: master role, two-edge synchroniser latency
        is_master = 1'b1; req_pin_in = 1'b0;
        write_en(2'b01); tick(); tick();
        #1 chk("R3", "clk_suspend pin low", clk_suspend, 1'b0);
        chk("R3", "req_pin_oe master", req_pin_oe, 1'b0);
        req_pin_in = 1'b1; tick();
        #1 chk("R3", "clk_suspend after one edge", clk_suspend, 1'b0);
        tick();
        #1 chk("R3", "clk_suspend after two edges", clk_suspend, 1'b1);
        req_pin_in = 1'b0; tick(); tick();
        #1 chk("R3", "clk_suspend released", clk_suspend, 1'b0);

        // Random mix against the model
        for (int i = 0; i < 2000; i++) begin
            is_master  = $urandom_range(0, 1);
            is_i2c     = $urandom_range(0, 1);
            tx_ready   = $urandom_range(0, 1);
            rx_ready   = $urandom_range(0, 1);
            busy       = ($urandom_range(0, 3) == 0);
            en_wr      = ($urandom_range(0, 3) == 0);
            en_wdata   = 2'($urandom_range(0, 3));
            soft_rst   = ($urandom_range(0, 31) == 0);
            req_pin_in = $urandom_range(0, 1);
            #1 check_all(tag_of(m_en, is_master, is_i2c));
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule